// File: doc/BRIEF.md
# SMBus Multi-Block Response Segmenter

This block holds one finished response message of up to 255 bytes and serves it to an SMBus host as a series of block reads. A response arrives as a byte stream with a sequence tag. The block keeps the message only when the tag matches the sequence number it expects next. The host then issues read-selection commands through the slave front end. Each command either restarts at block 0, steps to the next block, or re-fetches a block by number. The block assembles the chosen chunk into a 33-byte staging buffer, and a byte-read port drains that buffer one byte at a time.

A message of 32 bytes or fewer goes out as one block: a count byte followed by the message. A longer message is split into blocks with three layouts. The opening block carries a two-byte start header and 30 payload bytes. Each middle block carries a block number and 31 payload bytes. The closing block carries an end marker in place of the block number. Every chunk is assembled in the same clock edge that accepts the command, so the staging buffer and the command result are both ready one cycle after the command strobe.

The response input is a valid/ready stream that never applies back-pressure: `rsp_ready` is held high, and a beat transfers in every cycle that `rsp_valid` is high. The read output is also a valid/ready stream. `rd_valid` is always high, because the buffer always has a byte to offer. A byte transfers when `rd_ready` is high at a clock edge.

Top module: `smbus_block_segmenter`

## Requirements
- R1: The first beat of a response stream samples `rsp_tag`, and the message is kept only if the tag equals the expected sequence number. A kept message sets the stored length, the block index and the read position to 0 at its first beat. At its last beat it sets the length to the beat count and increments the expected sequence number, modulo 256. A response with any other tag changes nothing.
- R2: When a kept message has more than 255 beats, the extra beats are dropped and the stored length is 255. The message byte at index 2 is then replaced with 0xCA.
- R3: Command handling:
  - Code 0x03 sets the block index to 0 and loads a chunk.
  - Code 0x09 adds 1 to the block index and loads a chunk.
  - Code 0x0A with `cmd_arg_vld` high sets the block index to `cmd_arg` and loads a chunk.
  - Code 0x0A with no argument is an error and does not change the block index.
  - The block index takes its new value even when the load then fails.
  - Any other code produces no `cmd_done`, no `cmd_err` and no change of state.
- R4: A message of length L ≤ 32 has only block 0. Its chunk is L, then message bytes 0..L-1, then zero bytes up to 33 bytes. Any other block index fails.
- R5: For a message longer than 32 bytes, block 0 is the sequence 32, 0x00, 0x01, then message bytes 0..29.
- R6: For a message longer than 32 bytes, block n ≥ 1 starts at message offset 30 + 31·(n−1). If that offset is at or beyond the length, the load fails.
- R7: Layout of block n ≥ 1:
  - If more than 31 bytes remain from its offset, the chunk is 32, then n−1, then 31 payload bytes.
  - Otherwise it carries the remaining count R: the chunk is R+1, then 0xFF, then the R payload bytes.
  - Bytes after the payload are zero.
- R8: A load fails while the stored length is 0. This holds after reset and from the first beat of a kept response until its last beat.
- R9: `rd_data` shows the staging byte at the read position. Each `rd_ready` cycle advances the position, and `rd_valid` is always 1. At position 33, `rd_data` is 0xFF and the position no longer advances.
- R10: `cmd_done` pulses one cycle after every command with code 0x03, 0x09 or 0x0A. `cmd_err` pulses with it when the load failed. A failed load leaves the staging buffer and the read position unchanged. A successful load sets the read position to 0.
- R11: Reset clears the following to 0: the expected sequence number, the stored length, the block index, the read position and the staging buffer.
- R12: `rsp_ready` is always 1, so every `rsp_valid` cycle transfers one beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsp_valid | input | 1 | Response beat valid |
| rsp_ready | output | 1 | Response beat ready (constant 1) |
| rsp_data | input | 8 | Response byte |
| rsp_tag | input | 8 | Sequence tag, sampled on the first beat |
| rsp_last | input | 1 | Last beat of the response |
| cmd_valid | input | 1 | Command strobe from the slave front end |
| cmd_code | input | 8 | Command code |
| cmd_arg_vld | input | 1 | An argument byte accompanies the command |
| cmd_arg | input | 8 | First argument byte |
| cmd_done | output | 1 | A recognised command was handled (one cycle later) |
| cmd_err | output | 1 | The handled command failed |
| rd_valid | output | 1 | Read byte valid (constant 1) |
| rd_ready | input | 1 | Host takes the byte on `rd_data` |
| rd_data | output | 8 | Staging byte at the read position, or 0xFF past the end |

## Verification
Every result appears exactly one clock edge after its stimulus:
- `cmd_done` and `cmd_err` in the cycle after the command strobe.
- A new staging chunk on `rd_data` at position 0 in that same cycle.
- A read-position step in the cycle after `rd_ready`.
- A stored message in the cycle after its last beat.

No output has a combinational path from any input. The bench therefore drives inputs on the falling edge and advances its reference model on the rising edge. At each falling edge it compares `rd_data`, `cmd_done`, `cmd_err` and both ready/valid constants against the model, so every result is checked in exactly the cycle it is due.

// File: rtl/smbseg_pkg.sv
package smbseg_pkg;
  localparam int MSG_MAX_DEF = 255;
  localparam int CHUNK_DEF   = 32;

  localparam logic [7:0] OP_RESTART = 8'h03;
  localparam logic [7:0] OP_NEXT    = 8'h09;
  localparam logic [7:0] OP_RETRY   = 8'h0A;
  localparam logic [7:0] CC_TRUNC   = 8'hCA;
  localparam logic [7:0] END_MARK   = 8'hFF;
  localparam logic [7:0] PAST_END   = 8'hFF;
endpackage

// File: rtl/seg_msg_store.sv
module seg_msg_store
  import smbseg_pkg::*;
#(
  parameter int MSG_MAX = MSG_MAX_DEF,
  parameter int LW      = $clog2(MSG_MAX + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [7:0]               in_data,
  input  logic [7:0]               in_tag,
  input  logic                     in_last,
  output logic [MSG_MAX-1:0][7:0]  msg,
  output logic [LW-1:0]            msg_len,
  output logic                     accept_start
);
  localparam int CW = LW + 1;

  logic          busy_q;
  logic          keep_q;
  logic [CW-1:0] cnt_q;
  logic [7:0]    seq_q;
  logic          first_beat;
  logic          take;
  logic [CW-1:0] idx;
  logic [CW-1:0] idx_inc;

  assign first_beat   = in_valid && !busy_q;
  assign accept_start = first_beat && (in_tag == seq_q);
  assign take         = first_beat ? (in_tag == seq_q) : keep_q;
  assign idx          = first_beat ? '0 : cnt_q;
  // saturate one past the capacity so truncation stays visible
  assign idx_inc      = (idx > CW'(MSG_MAX)) ? idx : idx + CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      keep_q  <= 1'b0;
      cnt_q   <= '0;
      seq_q   <= '0;
      msg_len <= '0;
    end else if (in_valid) begin
      busy_q <= !in_last;
      keep_q <= take;
      if (take) begin
        if (first_beat) msg_len <= '0;
        if (idx < CW'(MSG_MAX)) msg[idx[LW-1:0]] <= in_data;
        cnt_q <= idx_inc;
        if (in_last) begin
          seq_q <= seq_q + 8'd1;
          if (idx >= CW'(MSG_MAX)) begin
            msg_len <= LW'(MSG_MAX);
            msg[2]  <= CC_TRUNC;
          end else begin
            msg_len <= LW'(idx + CW'(1));
          end
        end
      end
    end
  end
endmodule

// File: rtl/seg_chunk_build.sv
module seg_chunk_build
  import smbseg_pkg::*;
#(
  parameter int MSG_MAX = MSG_MAX_DEF,
  parameter int CHUNK   = CHUNK_DEF,
  parameter int LW      = $clog2(MSG_MAX + 1)
) (
  input  logic [MSG_MAX-1:0][7:0] msg,
  input  logic [LW-1:0]           msg_len,
  input  logic [7:0]              blk,
  output logic                    ok,
  output logic [CHUNK:0][7:0]     chunk
);
  localparam int FIRST_PAY = CHUNK - 2;
  localparam int MID_PAY   = CHUNK - 1;
  localparam int OW        = 16;

  logic [OW-1:0] len_w;
  logic [OW-1:0] off;
  logic [OW-1:0] rem;
  logic [OW-1:0] npay;

  always_comb begin
    chunk = '0;
    ok    = 1'b0;
    len_w = OW'(msg_len);
    off   = '0;
    rem   = '0;
    npay  = '0;
    if (len_w != '0) begin
      if (len_w <= OW'(CHUNK)) begin
        // single-block message: count byte then the message itself
        if (blk == 8'd0) begin
          ok       = 1'b1;
          chunk[0] = 8'(len_w);
          for (int i = 0; i < CHUNK; i++)
            if (OW'(i) < len_w) chunk[1+i] = msg[i];
        end
      end else if (blk == 8'd0) begin
        // opening block with start header
        ok       = 1'b1;
        chunk[0] = 8'(CHUNK);
        chunk[1] = 8'h00;
        chunk[2] = 8'h01;
        for (int i = 0; i < FIRST_PAY; i++) chunk[3+i] = msg[i];
      end else begin
        off = OW'(FIRST_PAY) + (OW'(blk) - OW'(1)) * OW'(MID_PAY);
        if (off < len_w) begin
          ok  = 1'b1;
          rem = len_w - off;
          if (rem > OW'(MID_PAY)) begin
            npay     = OW'(MID_PAY);
            chunk[1] = blk - 8'd1;
          end else begin
            npay     = rem;
            chunk[1] = END_MARK;
          end
          chunk[0] = 8'(npay + OW'(1));
          for (int i = 0; i < MID_PAY; i++)
            if (OW'(i) < npay) chunk[2+i] = msg[LW'(off) + LW'(i)];
        end
      end
    end
  end
endmodule

// File: rtl/seg_stage_buf.sv
module seg_stage_buf
  import smbseg_pkg::*;
#(
  parameter int STG = CHUNK_DEF + 1,
  parameter int PW  = $clog2(STG + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [STG-1:0][7:0] chunk,
  input  logic               clear_pos,
  input  logic               rd_take,
  output logic [7:0]         rd_data
);
  logic [STG-1:0][7:0] stg_q;
  logic [PW-1:0]       pos_q;
  logic                at_end;

  assign at_end  = (pos_q >= PW'(STG));
  assign rd_data = at_end ? PAST_END : stg_q[pos_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_q <= '0;
      pos_q <= '0;
    end else begin
      if (load) stg_q <= chunk;
      if (clear_pos || load)     pos_q <= '0;
      else if (rd_take && !at_end) pos_q <= pos_q + PW'(1);
    end
  end
endmodule

// File: rtl/smbus_block_segmenter.sv
module smbus_block_segmenter
  import smbseg_pkg::*;
#(
  parameter int MSG_MAX = MSG_MAX_DEF,
  parameter int CHUNK   = CHUNK_DEF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rsp_valid,
  output logic       rsp_ready,
  input  logic [7:0] rsp_data,
  input  logic [7:0] rsp_tag,
  input  logic       rsp_last,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  input  logic       cmd_arg_vld,
  input  logic [7:0] cmd_arg,
  output logic       cmd_done,
  output logic       cmd_err,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic [7:0] rd_data
);
  localparam int LW  = $clog2(MSG_MAX + 1);
  localparam int STG = CHUNK + 1;

  logic [MSG_MAX-1:0][7:0] msg;
  logic [LW-1:0]           msg_len;
  logic                    accept_start;
  logic [7:0]              blk_q;
  logic [7:0]              blk_sel;
  logic                    want_load;
  logic                    known_op;
  logic                    build_ok;
  logic [STG-1:0][7:0]     chunk;
  logic                    load_ok;

  assign rsp_ready = 1'b1;
  assign rd_valid  = 1'b1;

  seg_msg_store #(.MSG_MAX(MSG_MAX), .LW(LW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rsp_valid), .in_data(rsp_data), .in_tag(rsp_tag), .in_last(rsp_last),
    .msg(msg), .msg_len(msg_len), .accept_start(accept_start)
  );

  always_comb begin
    blk_sel   = blk_q;
    want_load = 1'b0;
    known_op  = 1'b0;
    unique case (cmd_code)
      OP_RESTART: begin known_op = 1'b1; want_load = 1'b1; blk_sel = 8'd0; end
      OP_NEXT:    begin known_op = 1'b1; want_load = 1'b1; blk_sel = blk_q + 8'd1; end
      OP_RETRY: begin
        known_op = 1'b1;
        if (cmd_arg_vld) begin
          want_load = 1'b1;
          blk_sel   = cmd_arg;
        end
      end
      default: ;
    endcase
  end

  seg_chunk_build #(.MSG_MAX(MSG_MAX), .CHUNK(CHUNK), .LW(LW)) u_build (
    .msg(msg), .msg_len(msg_len), .blk(blk_sel), .ok(build_ok), .chunk(chunk)
  );

  assign load_ok = cmd_valid && want_load && build_ok;

  seg_stage_buf #(.STG(STG)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .load(load_ok), .chunk(chunk), .clear_pos(accept_start),
    .rd_take(rd_ready), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q    <= '0;
      cmd_done <= 1'b0;
      cmd_err  <= 1'b0;
    end else begin
      if (accept_start)               blk_q <= '0;
      else if (cmd_valid && want_load) blk_q <= blk_sel;
      cmd_done <= cmd_valid && known_op;
      cmd_err  <= cmd_valid && known_op && !(want_load && build_ok);
    end
  end
endmodule

// File: rtl/smbseg_checker.sv
module smbseg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rsp_valid,
  input logic       cmd_valid,
  input logic [7:0] cmd_code,
  input logic       cmd_arg_vld,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       cmd_done,
  input logic       cmd_err
);
  logic known;
  assign known = (cmd_code == 8'h03) || (cmd_code == 8'h09) || (cmd_code == 8'h0A);

  // R10
  err_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> cmd_done);

  // R10
  done_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> $past(cmd_valid));

  // R3
  retry_noarg_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 8'h0A && !cmd_arg_vld) |=> cmd_err);

  // R3
  unknown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !known) |=> !cmd_done);

  // R4
  count_byte_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && !cmd_err) |-> (rd_data != 8'd0 && rd_data <= 8'd32));

  // R10
  fail_keeps_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_err && !$past(rd_ready) && !$past(rsp_valid)) |-> rd_data == $past(rd_data));
endmodule

bind smbus_block_segmenter smbseg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .cmd_valid(cmd_valid),
  .cmd_code(cmd_code), .cmd_arg_vld(cmd_arg_vld), .rd_ready(rd_ready),
  .rd_data(rd_data), .cmd_done(cmd_done), .cmd_err(cmd_err)
);

// File: tb/smbus_block_segmenter_tb.sv
`timescale 1ns/1ps
module smbus_block_segmenter_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       rsp_valid = 1'b0, rsp_last = 1'b0;
  logic [7:0] rsp_data = '0, rsp_tag = '0;
  logic       rsp_ready;
  logic       cmd_valid = 1'b0, cmd_arg_vld = 1'b0;
  logic [7:0] cmd_code = '0, cmd_arg = '0;
  logic       cmd_done, cmd_err, rd_valid;
  logic       rd_ready = 1'b0;
  logic [7:0] rd_data;

  smbus_block_segmenter u_dut (
    .clk(clk), .rst_n(rst_n),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_tag(rsp_tag), .rsp_last(rsp_last),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_arg_vld(cmd_arg_vld),
    .cmd_arg(cmd_arg), .cmd_done(cmd_done), .cmd_err(cmd_err),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  int n_chk = 0, n_fail = 0;
  string cur_req = "R11";
  bit finished = 0;

  // behavioural reference model
  byte unsigned m_msg[256];
  byte unsigned m_stg[33];
  byte unsigned m_q[$];
  int m_len = 0, m_seq = 0, m_blk = 0, m_pos = 0, m_cnt = 0;
  bit m_busy = 0, m_keep = 0, e_done = 0, e_err = 0;

  function automatic bit mk_chunk(int blk);
    int start, left, n;
    m_q.delete();
    if (m_len == 0) return 0;                       // R8
    if (m_len <= 32) begin                          // R4
      if (blk != 0) return 0;
      m_q.push_back(8'(m_len));
      for (int i = 0; i < m_len; i++) m_q.push_back(m_msg[i]);
    end else if (blk == 0) begin                    // R5
      m_q.push_back(8'd32); m_q.push_back(8'h00); m_q.push_back(8'h01);
      for (int i = 0; i < 30; i++) m_q.push_back(m_msg[i]);
    end else begin                                  // R6 R7
      start = 30 + (blk - 1) * 31;
      if (start >= m_len) return 0;
      left = m_len - start;
      n = (left > 31) ? 31 : left;
      m_q.push_back(8'(n + 1));
      m_q.push_back((left > 31) ? 8'(blk - 1) : 8'hFF);
      for (int i = 0; i < n; i++) m_q.push_back(m_msg[start + i]);
    end
    while (m_q.size() < 33) m_q.push_back(8'h00);
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_len = 0; m_seq = 0; m_blk = 0; m_pos = 0; m_busy = 0; m_keep = 0;
      e_done = 0; e_err = 0;
      for (int i = 0; i < 33; i++) m_stg[i] = 8'h00;
    end else begin
      bit ld;
      e_done = 0; e_err = 0; ld = 0;
      if (rd_ready && m_pos < 33) m_pos++;
      if (cmd_valid) begin
        case (cmd_code)
          8'h03: begin m_blk = 0; ld = 1; end
          8'h09: begin m_blk = (m_blk + 1) % 256; ld = 1; end
          8'h0A: if (cmd_arg_vld) begin m_blk = cmd_arg; ld = 1; end
                 else begin e_done = 1; e_err = 1; end
          default: ;
        endcase
        if (ld) begin
          e_done = 1;
          if (mk_chunk(m_blk)) begin
            for (int i = 0; i < 33; i++) m_stg[i] = m_q[i];
            m_pos = 0;
          end else e_err = 1;
        end
      end
      if (rsp_valid) begin
        if (!m_busy) begin
          m_keep = (rsp_tag == 8'(m_seq));
          m_cnt = 0;
          if (m_keep) begin m_len = 0; m_blk = 0; m_pos = 0; end
        end
        if (m_keep) begin
          if (m_cnt < 255) m_msg[m_cnt] = rsp_data;
          m_cnt++;
          if (rsp_last) begin
            m_len = (m_cnt > 255) ? 255 : m_cnt;
            if (m_cnt > 255) m_msg[2] = 8'hCA;
            m_seq = (m_seq + 1) % 256;
          end
        end
        m_busy = !rsp_last;
      end
    end
  end

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(cur_req, rd_data, (m_pos < 33) ? m_stg[m_pos] : 8'hFF, "rd_data");
      check("R10", cmd_done, e_done, "cmd_done");
      check("R10", cmd_err, e_err, "cmd_err");
      check("R9", rd_valid, 1, "rd_valid");
      check("R12", rsp_ready, 1, "rsp_ready");
    end
  end

  task automatic send_msg(int tag, int n, int seed);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rsp_valid = 1; rsp_tag = 8'(tag); rsp_data = 8'(seed + k * 7 + 1);
      rsp_last = (k == n - 1);
    end
    @(negedge clk);
    rsp_valid = 0; rsp_last = 0; rsp_tag = 8'hEE;
  endtask

  task automatic cmd(logic [7:0] code, bit av, logic [7:0] arg);
    @(negedge clk);
    cmd_valid = 1; cmd_code = code; cmd_arg_vld = av; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 0; cmd_arg_vld = 0;
  endtask

  task automatic rd(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rd_ready = 1;
    end
    @(negedge clk);
    rd_ready = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R11"; check("R11", rd_data, 8'h00, "reset rd_data");
    check("R11", cmd_done, 0, "reset cmd_done");

    cur_req = "R8";  cmd(8'h03, 0, 0);              // no message yet
    cur_req = "R1";  send_msg(0, 10, 3);
    cur_req = "R4";  cmd(8'h03, 0, 0); rd(12);
    cur_req = "R9";  rd(30);                        // runs past the end
    cur_req = "R4";  cmd(8'h09, 0, 0);              // only block 0 exists
    cur_req = "R1";  send_msg(5, 6, 40);            // wrong tag, ignored
    cmd(8'h03, 0, 0); rd(8);
    cur_req = "R8";  send_msg(1, 3, 9);             // partial view: run mid-load
    @(negedge clk); rsp_valid = 1; rsp_tag = 8'd2; rsp_data = 8'h55; rsp_last = 0;
    @(negedge clk); rsp_valid = 0;
    cmd(8'h03, 0, 0);                               // length zero while loading
    cur_req = "R6";
    for (int k = 0; k < 99; k++) begin
      @(negedge clk); rsp_valid = 1; rsp_data = 8'(k * 3 + 5); rsp_last = (k == 98);
    end
    @(negedge clk); rsp_valid = 0; rsp_last = 0;
    cur_req = "R5";  cmd(8'h03, 0, 0); rd(34);
    cur_req = "R7";  cmd(8'h09, 0, 0); rd(33);
    cmd(8'h09, 0, 0); rd(5);
    cmd(8'h09, 0, 0); rd(12);
    cur_req = "R6";  cmd(8'h09, 0, 0);              // offset beyond length
    cur_req = "R10"; rd(2); cmd(8'h09, 0, 0); rd(3);
    cur_req = "R3";  cmd(8'h0A, 1, 8'd2); rd(4);
    cmd(8'h0A, 0, 0); rd(2);
    cmd(8'h09, 0, 0); rd(3);                        // block 3 after retry of 2
    cmd(8'h42, 1, 8'd0); rd(2);                     // unknown code
    cmd(8'h0A, 1, 8'd0); rd(4);
    cur_req = "R2";  send_msg(3, 300, 11);
    cmd(8'h03, 0, 0); rd(8);
    cmd(8'h0A, 1, 8'd8); rd(33);
    cmd(8'h0A, 1, 8'd7); rd(4);
    cur_req = "R4";  send_msg(4, 32, 17); cmd(8'h03, 0, 0); rd(33);
    cur_req = "R7";  send_msg(5, 33, 23); cmd(8'h03, 0, 0); rd(3);
    cmd(8'h09, 0, 0); rd(6);
    cur_req = "R1";  send_msg(6, 2, 60); cmd(8'h09, 0, 0); cmd(8'h03, 0, 0); rd(4);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule